// File: doc/BRIEF.md
# Serial CRC-3 Frame Sealer and Checker

This block computes a three-bit cyclic check over a 32-bit serial-link word. It works in two modes. In seal mode the low three bits of the word are taken as zero, the check value is computed, and the value is placed in those three bits so the word can be transmitted. In check mode the check value is computed over every bit of a received word, including its check field, and the block returns a pass or fail verdict. A fail is also given when the two status flags of the word, bit 31 and bit 3, are both set.

A word enters through a valid/ready handshake. The default serial engine needs one clock per bit, starting from the most significant bit. A parameter selects a parallel engine instead, which gives the result one cycle after the word is taken. Results are held on the outputs until the next word is accepted.

Input back-pressure works as follows. `in_ready` is low for as long as the engine is busy. A word is taken only on a clock edge where `in_valid` and `in_ready` are both high. A `in_valid` that arrives while `in_ready` is low is not stored, so the source must hold it or present it again. The result side has no back-pressure. `done` marks the first cycle in which a result is valid, and the result stays valid after that until the next accepted word.

Top module: `crc3_frame_unit`

## Requirements
- R1: After reset, `busy` and `done` are 0, `in_ready` is 1, and `crc_out`, `frame_out` and `verdict_ok` are all 0.
- R2: A word and its mode are taken on a rising edge where `in_valid` and `in_ready` are both 1. With the serial engine, `in_ready` is 0 in the cycle that follows.
- R3: With the serial engine, `busy` is 1 for exactly 32 cycles after the word is taken. `done` is 1 for a single cycle, the cycle right after the last step, and `busy` is 0 in that cycle.
- R4: The register is three bits wide and is seeded with 3'b101. It takes one bit per step, from bit 31 down to bit 0. Each step shifts the register left, puts the new bit in bit 0, and XORs the result with 3'b011 when the old bit 2 was 1.
- R5: Seal mode is `in_mode`=0. Input bits [2:0] are treated as zero. `crc_out` is the computed value, `frame_out` is the input word with the value placed in bits [2:0], and `verdict_ok` is 0.
- R6: Check mode is `in_mode`=1. The value is computed over all 32 input bits. `frame_out` is the input word and `crc_out` is the computed value. `verdict_ok` is 1 only if that value is 0.
- R7: In check mode, a word with bit 31 and bit 3 both set gets `verdict_ok`=0 even when its check value is 0. A word with only one of the two bits set is judged on its check value alone.
- R8: `crc_out`, `frame_out` and `verdict_ok` keep their values from the `done` cycle until the next word is accepted.
- R9: A `in_valid` presented while the serial engine is busy has no effect: neither the result under way nor the result that follows is changed.
- R10: With `SERIAL`=0, `busy` stays 0 and `done` is 1 in the cycle after a word is taken. The results are the same as those of the serial engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take a word |
| in_frame | input | FRAME_W | Word to seal or check |
| in_mode | input | 1 | 0 = seal, 1 = check |
| busy | output | 1 | Serial steps in progress |
| done | output | 1 | One-cycle result marker |
| crc_out | output | 3 | Computed check value |
| frame_out | output | FRAME_W | Sealed word (seal mode) or received word (check mode) |
| verdict_ok | output | 1 | Check-mode pass flag |

## Verification
The bound checker tests these rules on every cycle:
- the length of the busy window and the single-cycle `done` pulse;
- `in_ready` dropping after a word is taken;
- a pass verdict only ever appearing with a zero check value and without both status flags set;
- results holding steady while the block is idle.

The actual check values can only be shown by the bench's scenarios, which compare them against a behavioural model. The same goes for the seal-mode masking of the low bits, the status-flag rule on words whose check value is correct, the rejection of a word offered while the engine is busy, and the match between the serial and parallel engines.

// File: rtl/crc3_pkg.sv
package crc3_pkg;
  localparam int CRC_W = 3;

  typedef enum logic {
    MODE_SEAL  = 1'b0,
    MODE_CHECK = 1'b1
  } crc_mode_e;

  // One MSB-first step of the CRC register
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] r,
                                                input logic             b,
                                                input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] n;
    n = {r[CRC_W-2:0], b};
    if (r[CRC_W-1]) n = n ^ poly;
    return n;
  endfunction
endpackage

// File: rtl/crc3_serial_engine.sv
module crc3_serial_engine
  import crc3_pkg::*;
#(
  parameter int               FRAME_W = 32,
  parameter logic [CRC_W-1:0] SEED    = 3'b101,
  parameter logic [CRC_W-1:0] POLY    = 3'b011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  output logic [CRC_W-1:0]   crc,
  output logic               busy,
  output logic               done
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      crc   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        crc   <= crc_step(crc, sh_q[FRAME_W-1], POLY);
        sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        sh_q  <= frame;
        crc   <= SEED;
        cnt_q <= '0;
        busy  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/crc3_parallel_engine.sv
module crc3_parallel_engine
  import crc3_pkg::*;
#(
  parameter int               FRAME_W = 32,
  parameter logic [CRC_W-1:0] SEED    = 3'b101,
  parameter logic [CRC_W-1:0] POLY    = 3'b011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  output logic [CRC_W-1:0]   crc,
  output logic               busy,
  output logic               done
);
  logic [CRC_W-1:0] chain [FRAME_W+1];

  assign chain[0] = SEED;
  for (genvar i = 0; i < FRAME_W; i++) begin : g_step
    assign chain[i+1] = crc_step(chain[i], frame[FRAME_W-1-i], POLY);
  end

  assign busy = 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc  <= '0;
      done <= 1'b0;
    end else begin
      done <= start;
      if (start) crc <= chain[FRAME_W];
    end
  end
endmodule

// File: rtl/crc3_verdict.sv
module crc3_verdict
  import crc3_pkg::*;
#(
  parameter int FRAME_W = 32,
  parameter int FLAG_A  = 31,
  parameter int FLAG_B  = 3
) (
  input  crc_mode_e          mode,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CRC_W-1:0]   crc,
  output logic [FRAME_W-1:0] frame_out,
  output logic               ok
);
  logic both_flags;
  assign both_flags = frame[FLAG_A] & frame[FLAG_B];

  always_comb begin
    if (mode == MODE_SEAL) begin
      frame_out = {frame[FRAME_W-1:CRC_W], crc};
      ok        = 1'b0;
    end else begin
      frame_out = frame;
      ok        = (crc == '0) && !both_flags;
    end
  end
endmodule

// File: rtl/crc3_frame_unit.sv
module crc3_frame_unit
  import crc3_pkg::*;
#(
  parameter int         FRAME_W  = 32,
  parameter bit         SERIAL   = 1'b1,
  parameter logic [2:0] SEED     = 3'b101,
  parameter logic [3:0] GEN_POLY = 4'hB,
  parameter int         FLAG_A   = 31,
  parameter int         FLAG_B   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [FRAME_W-1:0] in_frame,
  input  logic               in_mode,
  output logic               busy,
  output logic               done,
  output logic [2:0]         crc_out,
  output logic [FRAME_W-1:0] frame_out,
  output logic               verdict_ok
);
  localparam logic [CRC_W-1:0] POLY = GEN_POLY[CRC_W-1:0];

  logic               accept;
  logic [FRAME_W-1:0] masked;
  logic [FRAME_W-1:0] frame_q;
  crc_mode_e          mode_q;
  logic [CRC_W-1:0]   crc_w;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign masked   = (in_mode == MODE_SEAL) ? {in_frame[FRAME_W-1:CRC_W], {CRC_W{1'b0}}}
                                           : in_frame;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '0;
      mode_q  <= MODE_SEAL;
    end else if (accept) begin
      frame_q <= masked;
      mode_q  <= crc_mode_e'(in_mode);
    end
  end

  if (SERIAL) begin : g_serial
    crc3_serial_engine #(.FRAME_W(FRAME_W), .SEED(SEED), .POLY(POLY)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(accept), .frame(masked),
      .crc(crc_w), .busy(busy), .done(done));
  end else begin : g_parallel
    crc3_parallel_engine #(.FRAME_W(FRAME_W), .SEED(SEED), .POLY(POLY)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(accept), .frame(masked),
      .crc(crc_w), .busy(busy), .done(done));
  end

  assign crc_out = crc_w;

  crc3_verdict #(.FRAME_W(FRAME_W), .FLAG_A(FLAG_A), .FLAG_B(FLAG_B)) u_verdict (
    .mode(mode_q), .frame(frame_q), .crc(crc_w),
    .frame_out(frame_out), .ok(verdict_ok));
endmodule

// File: rtl/crc3_frame_unit_chk.sv
module crc3_frame_unit_chk #(
  parameter int FRAME_W = 32,
  parameter bit SERIAL  = 1'b1,
  parameter int FLAG_A  = 31,
  parameter int FLAG_B  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               busy,
  input logic               done,
  input logic [2:0]         crc_out,
  input logic [FRAME_W-1:0] frame_out,
  input logic               verdict_ok
);
  int unsigned busy_len;

  always_ff @(posedge clk) begin
    if (!rst_n)                    busy_len <= 0;
    else if (in_valid && in_ready) busy_len <= 0;
    else if (busy)                 busy_len <= busy_len + 1;
  end

  if (SERIAL) begin : g_ser
    assert_accept_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);
    assert_step_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (busy_len == FRAME_W));
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
    assert_busy_end_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
  end else begin : g_par
    assert_par_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> done);
  end

  assert_pass_zero_crc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_ok |-> (crc_out == 3'b000));
  assert_status_rule_R7: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_ok |-> !(frame_out[FLAG_A] && frame_out[FLAG_B]));
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |-> ($stable(crc_out) && $stable(frame_out) && $stable(verdict_ok)));
endmodule

bind crc3_frame_unit crc3_frame_unit_chk #(
  .FRAME_W(FRAME_W), .SERIAL(SERIAL), .FLAG_A(FLAG_A), .FLAG_B(FLAG_B)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .busy(busy), .done(done), .crc_out(crc_out), .frame_out(frame_out),
  .verdict_ok(verdict_ok)
);

// File: tb/crc3_frame_unit_bench.sv
module crc3_frame_unit_bench;
  localparam int FW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [FW-1:0] in_frame = '0;
  logic          in_mode = 1'b0;
  logic          in_ready, busy, done, verdict_ok;
  logic [2:0]    crc_out;
  logic [FW-1:0] frame_out;
  logic          p_valid, p_ready, p_busy, p_done, p_ok;
  logic [2:0]    p_crc;
  logic [FW-1:0] p_frame;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  string cur_tag = "R5";

  always #5 clk = ~clk;

  crc3_frame_unit #(.FRAME_W(FW), .SERIAL(1'b1)) u_crc3_frame_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_frame(in_frame), .in_mode(in_mode), .busy(busy), .done(done),
    .crc_out(crc_out), .frame_out(frame_out), .verdict_ok(verdict_ok));

  assign p_valid = in_valid && in_ready;
  crc3_frame_unit #(.FRAME_W(FW), .SERIAL(1'b0)) u_par (
    .clk(clk), .rst_n(rst_n), .in_valid(p_valid), .in_ready(p_ready),
    .in_frame(in_frame), .in_mode(in_mode), .busy(p_busy), .done(p_done),
    .crc_out(p_crc), .frame_out(p_frame), .verdict_ok(p_ok));

  // Specification of the check value, written directly from R4
  function automatic logic [2:0] spec_crc(input logic [31:0] f);
    logic [2:0] c = 3'b101;
    for (int i = 31; i >= 0; i--) begin
      logic top = c[2];
      c = {c[1:0], f[i]};
      if (top) c = c ^ 3'b011;
    end
    return c;
  endfunction

  // Behavioural reference model
  bit            m_busy, m_done, m_pdone;
  int            m_left;
  logic [2:0]    m_crc;
  logic [FW-1:0] m_frame;
  bit            m_ok;
  string         m_tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_pdone = 0; m_left = 0;
      m_crc = '0; m_frame = '0; m_ok = 0; m_tag = "R1";
    end else begin
      bit acc;
      acc = in_valid && !m_busy;
      m_done  = 0;
      m_pdone = acc;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin m_busy = 0; m_done = 1; end
      end else if (acc) begin
        logic [FW-1:0] f;
        m_busy = 1; m_left = FW; m_tag = cur_tag;
        if (in_mode == 1'b0) begin
          f = {in_frame[FW-1:3], 3'b000};
          m_crc = spec_crc(f); m_frame = f | {29'd0, m_crc}; m_ok = 0;
        end else begin
          f = in_frame;
          m_crc = spec_crc(f); m_frame = f;
          m_ok = (m_crc == 3'b000) && !(f[31] && f[3]);
        end
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      string rt;
      rt = m_done ? m_tag : (m_tag == "R1" ? "R1" : "R8");
      chk("R2", "in_ready", 64'(in_ready), 64'(!m_busy));
      chk("R3", "busy", 64'(busy), 64'(m_busy));
      chk("R3", "done", 64'(done), 64'(m_done));
      if (!m_busy) begin
        chk(rt, "crc_out", 64'(crc_out), 64'(m_crc));
        chk(rt, "frame_out", 64'(frame_out), 64'(m_frame));
        chk(rt, "verdict_ok", 64'(verdict_ok), 64'(m_ok));
      end
      chk("R10", "par busy", 64'(p_busy), 64'(0));
      chk("R10", "par done", 64'(p_done), 64'(m_pdone));
      if (m_pdone) begin
        chk("R10", "par crc", 64'(p_crc), 64'(m_crc));
        chk("R10", "par frame", 64'(p_frame), 64'(m_frame));
        chk("R10", "par ok", 64'(p_ok), 64'(m_ok));
      end
    end
  end

  task automatic send(input logic [FW-1:0] f, input logic md, input string tag);
    @(negedge clk);
    cur_tag = tag; in_frame = f; in_mode = md; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (FW + 2) @(negedge clk);
  endtask

  initial begin
    logic [FW-1:0] w;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "busy", 64'(busy), 64'(0));
    chk("R1", "done", 64'(done), 64'(0));
    chk("R1", "in_ready", 64'(in_ready), 64'(1));
    chk("R1", "frame_out", 64'(frame_out), 64'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R4/R5: sealing of several words
    send(32'h0000_0000, 1'b0, "R4");
    send(32'h0280_0000, 1'b0, "R5");
    send(32'hFFFF_FFF8, 1'b0, "R5");
    send(32'h1234_5677, 1'b0, "R5");  // low bits ignored in seal mode
    // R6: sealed words pass, corrupted words fail
    w = 32'h0A40_1230; w = w | {29'd0, spec_crc(w)};
    send(w, 1'b1, "R6");
    send(w ^ 32'h0001_0000, 1'b1, "R6");
    send(w ^ 32'h0000_0001, 1'b1, "R6");
    // R7: status flag rule with correct check values
    w = 32'h8000_0008; w = w | {29'd0, spec_crc(w)};
    send(w, 1'b1, "R7");
    w = 32'h8000_0000; w = w | {29'd0, spec_crc(w)};
    send(w, 1'b1, "R7");
    w = 32'h0000_0008; w = w | {29'd0, spec_crc(w)};
    send(w, 1'b1, "R7");
    // R9: offer another word while busy
    @(negedge clk);
    cur_tag = "R9"; in_frame = 32'hC0DE_0000; in_mode = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    in_frame = 32'hDEAD_BEEF; in_mode = 1'b1; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    repeat (FW) @(negedge clk);
    // R2: back-to-back offers with in_valid held high
    cur_tag = "R2"; in_frame = 32'h5555_5550; in_mode = 1'b0; in_valid = 1'b1;
    repeat (2 * FW + 4) @(negedge clk);
    in_valid = 1'b0;
    // R8: results hold while idle
    repeat (FW + 10) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      vectors++; errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule